// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block guards a system against runaway software. A free-running prescaler counts clock cycles and advances an 8-bit up-counting timer once per full prescaler period. If software does not reload the timer before it rolls over from FFh to 00h, the block raises a one-clock reset request for the system reset logic. Software reloads the timer through a byte-wide register interface. The interface has two single-cycle write strobes, one for the control register and one for the timer register, and both registers can be read at all times.

The timer is protected against accidental writes. A timer write takes effect only while the control register holds the unlock key 5Ah. A successful reload also clears the prescaler and sets the control register to 00h, so each reload needs the key written again. The block leaves reset disabled, with the control register at A5h. That value holds the prescaler and the timer at zero. The first control write after reset starts the watchdog, whatever value it writes, and only a system reset stops it again.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, ctl_q reads A5h, tim_q reads 00h and reset_req is low. While no control write has occurred, the timer stays at 00h and reset_req stays low.
- R2: The first control write after reset enables the watchdog, whatever value it writes. Later control writes of any value, including A5h, never disable it.
- R3: A control write makes ctl_q show the written byte from the next cycle on.
- R4: While enabled and ctl_q is not A5h, the timer increments once every 2^PRE_W clock cycles (16384 by default). Counting begins with the cycle after the control write that left A5h.
- R5: While ctl_q holds A5h, the prescaler and the timer are held at zero.
- R6: A timer write while ctl_q holds 5Ah loads the written byte into the timer, clears the prescaler and sets ctl_q to 00h. Another timer write then has no effect until 5Ah is written again.
- R7: A timer write while ctl_q is not 5Ah leaves the timer unchanged and the prescaler running.
- R8: When the timer advances from FFh to 00h, reset_req is high for exactly one cycle. That cycle is the one in which tim_q first reads 00h.
- R9: After a reload with value L, reset_req rises (256 − L) × 2^PRE_W cycles after the reload edge, unless the timer is reloaded again first.
- R10: When both strobes are active in the same cycle, the timer write is judged against the control value held before that edge, and the control register takes the written byte.
- R11: Asserting rst at any time returns the block to the state of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that also advances the prescaler |
| rst | input | 1 | Synchronous active-high system reset |
| ctl_we | input | 1 | Single-cycle write strobe for the control register |
| tim_we | input | 1 | Single-cycle write strobe for the timer register |
| wdata | input | 8 | Write data for either register |
| ctl_q | output | 8 | Current control register value |
| tim_q | output | 8 | Current timer value |
| reset_req | output | 1 | One-cycle system reset request on timer overflow |

## Verification
Most faults show at the ports within one cycle. A wrong unlock decision or a wrong control update shows as a wrong ctl_q or tim_q on the cycle after the write. A wrong prescaler state is hidden until the next timer step, so it shows only up to 2^PRE_W cycles later, as a tim_q increment on the wrong cycle, and finally as reset_req rising at the wrong time. The bench therefore runs the prescaler narrow. It compares every output against a behavioural model on every clock and measures the full timeout from a reload.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned TIM_W = 8;

    localparam logic [TIM_W-1:0] CTL_HOLD_VAL = 8'hA5;
    localparam logic [TIM_W-1:0] CTL_KEY_VAL  = 8'h5A;
    localparam logic [TIM_W-1:0] CTL_LOCK_VAL = 8'h00;

    typedef struct packed {
        logic enabled;
        logic hold;
        logic run;
        logic load;
    } wdt_ctl_s;

    function automatic logic is_key(input logic [TIM_W-1:0] v);
        return v == CTL_KEY_VAL;
    endfunction

    function automatic logic is_hold(input logic [TIM_W-1:0] v);
        return v == CTL_HOLD_VAL;
    endfunction

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic             tim_we,
    input  logic [TIM_W-1:0] wdata,
    output logic [TIM_W-1:0] ctl_q,
    output wdt_ctl_s         st
);

    logic [TIM_W-1:0] ctl_r;
    logic             en_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_r <= CTL_HOLD_VAL;
            en_r  <= 1'b0;
        end else begin
            if (ctl_we) begin
                ctl_r <= wdata;
                en_r  <= 1'b1;
            end else if (st.load) begin
                ctl_r <= CTL_LOCK_VAL;
            end
        end
    end

    always_comb begin
        st.enabled = en_r;
        st.hold    = is_hold(ctl_r);
        st.run     = en_r && !is_hold(ctl_r);
        st.load    = tim_we && is_key(ctl_r);
    end

    assign ctl_q = ctl_r;

    assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        st.enabled |=> st.enabled);

    assert_write_enables_R2: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> st.enabled);

    assert_ctl_write_R3: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> ctl_q == $past(wdata));

    assert_key_selfclear_R6: assert property (@(posedge clk) disable iff (rst)
        (st.load && !ctl_we) |=> ctl_q == CTL_LOCK_VAL);

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned PRE_W = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    output logic carry
);

    logic [PRE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign carry = run && !clear && (&cnt);

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
        clear |=> cnt == '0);

    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(cnt));

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             load,
    input  logic [TIM_W-1:0] ldata,
    input  logic             tick,
    output logic [TIM_W-1:0] tim_q,
    output logic             ovf_q
);

    logic [TIM_W-1:0] tim_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            tim_r <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= tick && !hold && !load && (&tim_r);
            if (hold) begin
                tim_r <= '0;
            end else if (load) begin
                tim_r <= ldata;
            end else if (tick) begin
                tim_r <= tim_r + 1'b1;
            end
        end
    end

    assign tim_q = tim_r;

    assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> tim_q == '0);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> !ovf_q);

    assert_hold_zero_R5: assert property (@(posedge clk) disable iff (rst)
        hold |=> tim_q == '0);

    assert_load_value_R6: assert property (@(posedge clk) disable iff (rst)
        (load && !hold) |=> tim_q == $past(ldata));

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int unsigned PRE_W = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  logic       tim_we,
    input  logic [7:0] wdata,
    output logic [7:0] ctl_q,
    output logic [7:0] tim_q,
    output logic       reset_req
);

    wdt_ctl_s st;
    logic     tick;

    wdt_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ctl_we (ctl_we),
        .tim_we (tim_we),
        .wdata  (wdata),
        .ctl_q  (ctl_q),
        .st     (st)
    );

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (st.run),
        .clear (st.hold || st.load),
        .carry (tick)
    );

    wdt_timer u_tim (
        .clk   (clk),
        .rst   (rst),
        .hold  (st.hold),
        .load  (st.load),
        .ldata (wdata),
        .tick  (tick),
        .tim_q (tim_q),
        .ovf_q (reset_req)
    );

    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !st.enabled |-> (tim_q == 8'h00 && !reset_req));

    assert_reset_state_R11: assert property (@(posedge clk)
        rst |=> (ctl_q == CTL_HOLD_VAL && tim_q == 8'h00 && !reset_req));

endmodule

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;

    localparam int PRE_W = 4;
    localparam int PER   = 1 << PRE_W;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic       tim_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] ctl_q;
    logic [7:0] tim_q;
    logic       reset_req;

    int n_chk = 0;
    int n_err = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_pre = 0;
    int m_tim = 0;
    int m_ctl = 8'hA5;
    bit m_en = 0;
    bit m_req = 0;

    always #2 clk = ~clk;

    wdt_keyed #(.PRE_W(PRE_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .tim_we    (tim_we),
        .wdata     (wdata),
        .ctl_q     (ctl_q),
        .tim_q     (tim_q),
        .reset_req (reset_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit ok_load;
        bit carry;
        if (rst) begin
            m_pre = 0; m_tim = 0; m_ctl = 8'hA5; m_en = 0; m_req = 0;
        end else begin
            ok_load = tim_we && (m_ctl == 8'h5A);
            carry = 0;
            if (m_ctl == 8'hA5) begin
                m_pre = 0; m_tim = 0;
            end else if (ok_load) begin
                m_pre = 0; m_tim = int'(wdata);
            end else if (m_en) begin
                if (m_pre == PER - 1) begin
                    m_pre = 0; carry = 1;
                end else begin
                    m_pre++;
                end
            end
            m_req = carry && (m_tim == 255);
            if (carry) m_tim = (m_tim + 1) % 256;
            if (ctl_we) begin
                m_ctl = int'(wdata); m_en = 1;
            end else if (ok_load) begin
                m_ctl = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(cur_req, "model ctl_q", int'(ctl_q), m_ctl);
            chk(cur_req, "model tim_q", int'(tim_q), m_tim);
            chk(cur_req, "model reset_req", int'(reset_req), int'(m_req));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1'b1; wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_tim(input logic [7:0] v);
        tim_we = 1'b1; wdata = v;
        @(negedge clk);
        tim_we = 1'b0;
    endtask

    task automatic wr_both(input logic [7:0] v);
        ctl_we = 1'b1; tim_we = 1'b1; wdata = v;
        @(negedge clk);
        ctl_we = 1'b0; tim_we = 1'b0;
    endtask

    task automatic measure(input string req, input int load_val);
        int n = 0;
        while (!reset_req && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(req, "timeout cycles", n, (256 - load_val) * PER);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired in %s actual=hung expected=done", cur_req);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        cur_req = "R1";
        chk("R1", "ctl_q after reset", int'(ctl_q), 8'hA5);
        chk("R1", "tim_q after reset", int'(tim_q), 0);
        chk("R1", "reset_req after reset", int'(reset_req), 0);
        idle(100);
        chk("R1", "tim_q while disabled", int'(tim_q), 0);

        cur_req = "R5";
        wr_ctl(8'hA5);
        idle(100);
        chk("R5", "tim_q held under A5", int'(tim_q), 0);
        chk("R3", "ctl_q readback A5", int'(ctl_q), 8'hA5);

        cur_req = "R7";
        wr_tim(8'h40);
        chk("R7", "tim write under A5 ignored", int'(tim_q), 0);

        cur_req = "R4";
        wr_ctl(8'h33);
        chk("R3", "ctl_q readback 33", int'(ctl_q), 8'h33);
        idle(3 * PER);
        chk("R4", "tim_q after three periods", int'(tim_q), 3);

        cur_req = "R7";
        wr_tim(8'h80);
        chk("R7", "tim write without key ignored", int'(tim_q), 3);
        idle(PER);
        chk("R7", "prescaler kept running", int'(tim_q), 4);

        cur_req = "R6";
        wr_ctl(8'h5A);
        wr_tim(8'hF0);
        chk("R6", "tim_q loaded", int'(tim_q), 8'hF0);
        chk("R6", "ctl_q locked", int'(ctl_q), 8'h00);

        cur_req = "R9";
        measure("R9", 8'hF0);
        chk("R8", "reset_req high at wrap", int'(reset_req), 1);
        chk("R8", "tim_q zero at wrap", int'(tim_q), 0);
        idle(1);
        chk("R8", "reset_req single cycle", int'(reset_req), 0);

        cur_req = "R6";
        wr_tim(8'h10);
        chk("R6", "second write blocked", int'(tim_q) == 8'h10 ? 1 : 0, 0);

        cur_req = "R10";
        wr_ctl(8'h5A);
        wr_both(8'h77);
        chk("R10", "tim loaded on old key", int'(tim_q), 8'h77);
        chk("R10", "ctl takes written byte", int'(ctl_q), 8'h77);
        wr_both(8'h5A);
        chk("R10", "tim not loaded on new key", int'(tim_q), 8'h77);
        chk("R10", "ctl now key", int'(ctl_q), 8'h5A);

        cur_req = "R2";
        wr_ctl(8'hA5);
        idle(20);
        chk("R2", "A5 holds timer", int'(tim_q), 0);
        wr_ctl(8'h11);
        idle(2 * PER);
        chk("R2", "still enabled after A5", int'(tim_q), 2);

        cur_req = "R9";
        wr_ctl(8'h5A);
        wr_tim(8'h00);
        measure("R9", 0);

        cur_req = "R11";
        idle(37);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11", "ctl_q after mid-run reset", int'(ctl_q), 8'hA5);
        chk("R11", "tim_q after mid-run reset", int'(tim_q), 0);
        chk("R11", "reset_req after mid-run reset", int'(reset_req), 0);
        idle(3 * PER);
        chk("R11", "disabled again after reset", int'(tim_q), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule